// File: doc/BRIEF.md
# Display Memory Access Engine

This block carries out the display-memory commands of a graphic LCD controller. It handles byte writes, byte reads, single-bit set and single-bit clear. It also handles the two loads that place the 16-bit cursor address. Every memory command works at the cursor, and the cursor moves forward by one once the command has finished with memory.

Reads are pipelined. A read command returns the byte held in a prefetch latch. It then refills that latch from the cursor location and advances the cursor. Because of this, each read returns the byte at the address just before the current cursor. The first read after the cursor has been loaded returns old latch contents, and the host discards it as a dummy.

Bit set and bit clear are read-modify-write sequences on the addressed byte. Memory is a synchronous single-port RAM that returns read data one cycle after a granted request. A refresh scanner shares that RAM through a request/grant pair. The busy output lasts for a cycle count set by the operation and by the character cell width HP.

Top module: `vram_engine`

## Requirements
- R1: After reset, the following are all low: `busy`, `err`, `rd_valid` and `mem_req`. `cursor` is 0 and the prefetch latch holds 0.
- R2: The command code is given by `cmd_op`: 0 writes a byte, 1 reads a byte, 2 clears a bit, 3 sets a bit, 4 loads the low cursor byte and 5 loads the high cursor byte. Codes 6 and 7 do nothing. A write (op 0) stores `cmd_data` at the cursor, and the cursor then increases by one.
- R3: A read (op 1) returns the prefetch latch on `rd_data`, with `rd_valid` high for one cycle in the cycle after acceptance. The read then loads the latch from the byte at the cursor and advances the cursor. A cursor load does not refill the latch, so the first read after a load returns stale data.
- R4: For bit clear (op 2) and bit set (op 3), `cmd_data[2:0]` holds NB-1. A value of 0 selects bit 0 and a value of 7 selects bit 7. The selected bit of the byte at the cursor is forced to 0 (clear) or 1 (set). All other bits of that byte keep their values, and `cmd_data[7:3]` is ignored. The cursor then increases by one.
- R5: HP is `hp_m1`+1. With the grant given at once, `busy` stays high for exactly HP+2 cycles after a read or write is accepted. After a bit set or bit clear it stays high for exactly 2(HP+1) cycles. `mem_req` is only ever high while `busy` is high.
- R6: A command that arrives while `busy` is high is dropped and changes neither the memory nor the cursor. In the next cycle, `err` pulses high for one cycle.
- R7: Op 4 replaces `cursor[7:0]` and op 5 replaces `cursor[15:8]`, and both take effect in the next cycle. Neither load raises `busy`. In character mode (`gfx_mode`=0), bits 7:4 of the high byte are stored as 0.
- R8: The cursor wraps from 0xFFFF to 0x0000 in graphics mode and from 0x0FFF to 0x0000 in character mode.
- R9: `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_gnt` is seen. Until then the cursor does not move and no memory write happens. `mem_we` is high only together with `mem_req`.
- R10: In character mode, `mem_addr[15:12]` is 0 whenever `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 8 | Write byte, bit select, or cursor byte |
| gfx_mode | input | 1 | 1 selects graphics mode, 0 selects character mode |
| hp_m1 | input | 3 | Character cell width minus one |
| busy | output | 1 | Engine occupied |
| err | output | 1 | Pulse when a command is dropped |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 8 | Read data |
| cursor | output | 16 | Current cursor address |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory access grant |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after a granted request |

## Verification
The prefetch latch is not visible directly, so a latch that goes wrong shows up one read later: the next `rd_data` carries the wrong byte. After a cursor load, the dummy read is where a latch wrongly refilled on load would show. A wrong cursor step shows up on `cursor` in the cycle after the granted access, and in the address of the next access. A faulty read-modify-write leaves an incorrect byte in memory that is visible in the same cycle as the write-back. A wrong busy count shifts the falling edge of `busy`, which is measured to the exact cycle.

// File: rtl/vram_engine.sv
module vram_engine #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int CAW = 12,
  parameter int HPW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  input  logic          gfx_mode,
  input  logic [HPW-1:0] hp_m1,
  output logic          busy,
  output logic          err,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] cursor,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int BW = $clog2(DW);
  localparam int CW = HPW + 3;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_CLR = 3'd2,
                         OP_SET = 3'd3, OP_LLO = 3'd4, OP_LHI = 3'd5;
  localparam logic [AW-1:0] CHAR_MASK = {{(AW-CAW){1'b0}}, {CAW{1'b1}}};
  localparam logic [DW-1:0] HI_CHAR   = {{(AW-CAW){1'b0}}, {(CAW-DW){1'b1}}};

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA, S_WB} st_t;

  st_t           st;
  logic [2:0]    op;
  logic [DW-1:0] wbyte, pf;
  logic [BW-1:0] bsel;
  logic [CW-1:0] cnt;

  wire            accept   = cmd_valid && !busy;
  wire [AW-1:0]   amask    = gfx_mode ? {AW{1'b1}} : CHAR_MASK;
  wire [AW-1:0]   cur_next = (cursor + 1'b1) & amask;
  wire [CW-1:0]   hp       = CW'(hp_m1) + 1'b1;
  wire [CW-1:0]   n_rw     = hp + CW'(2);
  wire [CW-1:0]   n_bit    = (hp + 1'b1) << 1;
  wire [DW-1:0]   onehot   = DW'(1) << bsel;
  wire [DW-1:0]   modified = (op == OP_SET) ? (mem_rdata | onehot) : (mem_rdata & ~onehot);

  assign busy      = (st != S_IDLE) || (cnt != '0);
  assign mem_req   = (st == S_REQ) || (st == S_WB);
  assign mem_we    = ((st == S_REQ) && (op == OP_WR)) || (st == S_WB);
  assign mem_addr  = cursor & amask;
  assign mem_wdata = wbyte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op       <= OP_WR;
      wbyte    <= '0;
      pf       <= '0;
      bsel     <= '0;
      cnt      <= '0;
      cursor   <= '0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      err      <= cmd_valid && busy;
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          case (cmd_op)
            OP_LLO: cursor <= {cursor[AW-1:DW], cmd_data};
            OP_LHI: cursor <= {cmd_data & (gfx_mode ? {DW{1'b1}} : HI_CHAR), cursor[DW-1:0]};
            OP_WR, OP_RD, OP_CLR, OP_SET: begin
              op    <= cmd_op;
              wbyte <= cmd_data;
              bsel  <= cmd_data[BW-1:0];
              cnt   <= cmd_op[1] ? n_bit : n_rw;
              st    <= S_REQ;
              if (cmd_op == OP_RD) begin
                rd_data  <= pf;
                rd_valid <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        S_REQ: if (mem_gnt) begin
          if (op == OP_WR) begin
            cursor <= cur_next;
            st     <= S_IDLE;
          end else begin
            st <= S_DATA;
          end
        end
        S_DATA: begin
          if (op == OP_RD) begin
            pf     <= mem_rdata;
            cursor <= cur_next;
            st     <= S_IDLE;
          end else begin
            wbyte <= modified;
            st    <= S_WB;
          end
        end
        S_WB: if (mem_gnt) begin
          cursor <= cur_next;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vram_engine_chk.sv
module vram_engine_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          gfx_mode,
  input logic          busy,
  input logic          err,
  input logic          rd_valid,
  input logic [AW-1:0] cursor,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we
);
  p_we_has_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_req_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_valid && busy));

  p_rdv_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_char_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!gfx_mode && mem_req) |-> (mem_addr[AW-1:12] == '0));

  p_cursor_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cursor != $past(cursor)) && !$past(cmd_valid && !busy && cmd_op[2]) && $stable(gfx_mode))
      |-> (cursor == (gfx_mode ? AW'($past(cursor) + 1'b1)
                               : {{(AW-12){1'b0}}, 12'($past(cursor[11:0]) + 1'b1)})));
endmodule

bind vram_engine vram_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .gfx_mode(gfx_mode), .busy(busy), .err(err), .rd_valid(rd_valid),
  .cursor(cursor), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_we(mem_we)
);

// File: tb/sim_vram_engine.sv
`timescale 1ns/1ps
module sim_vram_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'd0;
  logic gfx_mode = 1'b1;
  logic [2:0] hp_m1 = 3'd5;
  logic busy, err, rd_valid, mem_req, mem_we;
  logic [7:0] rd_data, mem_wdata;
  logic [15:0] cursor, mem_addr;
  logic mem_gnt = 1'b1;
  logic [7:0] mem_rdata = 8'd0;
  logic [7:0] vm [0:4095];

  int checks = 0, errors = 0, blen = 0;
  logic rv_s;
  logic [7:0] rd_s;
  bit done = 0;

  always #2.5 clk = ~clk;

  vram_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .gfx_mode(gfx_mode), .hp_m1(hp_m1), .busy(busy),
    .err(err), .rd_valid(rd_valid), .rd_data(rd_data), .cursor(cursor),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) if (mem_req && mem_gnt) begin
    if (mem_we) vm[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= vm[mem_addr[11:0]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    rv_s = rd_valid; rd_s = rd_data;
    blen = 0;
    while (busy) begin blen++; @(negedge clk); end
  endtask

  task automatic set_cur(input logic [15:0] a);
    issue(3'd4, a[7:0]);
    issue(3'd5, a[15:8]);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 cursor", cursor, 16'h0000);
  endtask

  task automatic t_write;
    set_cur(16'h0010);
    chk("R7 load no busy", blen, 0);
    chk("R7 cursor loaded", cursor, 16'h0010);
    issue(3'd0, 8'hAA);
    chk("R5 write busy len", blen, 8);
    issue(3'd0, 8'hBB);
    issue(3'd0, 8'hCC);
    chk("R2 byte0", vm[12'h010], 8'hAA);
    chk("R2 byte1", vm[12'h011], 8'hBB);
    chk("R2 byte2", vm[12'h012], 8'hCC);
    chk("R2 cursor advance", cursor, 16'h0013);
  endtask

  task automatic t_read;
    set_cur(16'h0010);
    issue(3'd1, 8'h00);
    chk("R3 rd_valid", rv_s, 1);
    chk("R3 dummy read is reset latch", rd_s, 8'h00);
    chk("R5 read busy len", blen, 8);
    issue(3'd1, 8'h00);
    chk("R3 read AA", rd_s, 8'hAA);
    issue(3'd1, 8'h00);
    chk("R3 read BB", rd_s, 8'hBB);
    chk("R3 cursor after reads", cursor, 16'h0013);
    set_cur(16'h0011);
    issue(3'd1, 8'h00);
    chk("R3 stale after load", rd_s, 8'hCC);
    issue(3'd1, 8'h00);
    chk("R3 read after dummy", rd_s, 8'hBB);
    @(negedge clk);
    chk("R3 strobe one cycle", rd_valid, 0);
  endtask

  task automatic t_bits;
    set_cur(16'h0020);
    issue(3'd0, 8'h0F);
    issue(3'd0, 8'hFF);
    set_cur(16'h0020);
    issue(3'd3, 8'hFF);
    chk("R5 bit busy len", blen, 14);
    chk("R4 set bit7 upper ignored", vm[12'h020], 8'h8F);
    issue(3'd2, 8'h00);
    chk("R4 clear bit0", vm[12'h021], 8'hFE);
    chk("R4 cursor advance", cursor, 16'h0022);
    set_cur(16'h0021);
    issue(3'd2, 8'h04);
    chk("R4 clear bit4", vm[12'h021], 8'hEE);
  endtask

  task automatic t_hp;
    hp_m1 = 3'd7;
    issue(3'd0, 8'h01);
    chk("R5 write HP8", blen, 10);
    issue(3'd3, 8'h01);
    chk("R5 bit HP8", blen, 18);
    hp_m1 = 3'd0;
    issue(3'd1, 8'h00);
    chk("R5 read HP1", blen, 3);
    issue(3'd2, 8'h01);
    chk("R5 bit HP1", blen, 4);
    hp_m1 = 3'd5;
  endtask

  task automatic t_drop;
    set_cur(16'h0040);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_data = 8'h11;
    @(negedge clk);
    cmd_data = 8'h22;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6 err pulse", err, 1);
    @(negedge clk);
    chk("R6 err single", err, 0);
    while (busy) @(negedge clk);
    chk("R6 first kept", vm[12'h040], 8'h11);
    chk("R6 second dropped", vm[12'h041], 8'h00);
    chk("R6 cursor once", cursor, 16'h0041);
  endtask

  task automatic t_wrap;
    set_cur(16'hFFFF);
    issue(3'd0, 8'h3C);
    chk("R8 graphics wrap", cursor, 16'h0000);
    gfx_mode = 1'b0;
    set_cur(16'hFFFF);
    chk("R7 char high masked", cursor, 16'h0FFF);
    issue(3'd0, 8'h5A);
    chk("R10 char addr", vm[12'hFFF], 8'h5A);
    chk("R8 char wrap", cursor, 16'h0000);
    issue(3'd6, 8'h77);
    chk("R2 op6 no effect", cursor, 16'h0000);
    gfx_mode = 1'b1;
  endtask

  task automatic t_stall;
    set_cur(16'h0050);
    mem_gnt = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_data = 8'h5A;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 busy held", busy, 1);
    chk("R9 req held", mem_req, 1);
    chk("R9 cursor held", cursor, 16'h0050);
    chk("R9 no write", vm[12'h050], 8'h00);
    mem_gnt = 1'b1;
    @(negedge clk);
    chk("R9 write on grant", vm[12'h050], 8'h5A);
    chk("R9 cursor on grant", cursor, 16'h0051);
    while (busy) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) vm[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write;
    t_read;
    t_bits;
    t_hp;
    t_drop;
    t_wrap;
    t_stall;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end
endmodule